// File: doc/BRIEF.md
# Station Address Loader

After reset, or whenever it is told to start, this block fetches a 48-bit network station address from a word-organised nonvolatile memory. It reaches that memory through a small controller that offers two registers. A command register accepts read requests and shows a busy flag. A data register returns one 16-bit word once the busy flag drops.

The loader reads three consecutive words, beginning at word address 0x10. It writes one command per word and polls the busy flag, and it gives up on a word after a bounded number of polls. The three words are packed into a 48-bit address register. A one-cycle done pulse marks the end of the sequence. A sticky timeout flag records whether any word had to be replaced with zero because the controller never became ready.

Top module: `sta_addr_loader`

## Requirements
- R1: After synchronous active-high reset, `addrOut` is 0, `done` and `timeout` are 0, and `cmdWr` stays 0 until `start` is seen.
- R2: A `start` sampled high while idle makes `cmdWr` high in the next cycle, with `cmdWord` = 0x0210.
- R3: Exactly three commands are written per load, with values 0x0200 ORed with word addresses 0x11 and 0x12 after the first. `cmdWr` is high for one cycle per word, and the next command follows only after the previous word is captured.
- R4: The data word is taken only in a cycle where bit 15 of `ctrlStatus` (busy) is 0. Data presented while busy is never stored.
- R5: Word k (k = 0, 1, 2) is stored at `addrOut[16k+15:16k]`. Its low byte is the earlier address byte, so `addrOut[7:0]` is the first byte.
- R6: If busy is still 1 on the 1000th status check of a word, that word is stored as 0x0000, `timeout` is set, and the load goes on with the next word. If busy is clear on the 1000th check, the word is captured normally.
- R7: `done` is high for exactly one cycle, in the cycle after the third word is captured or replaced.
- R8: `start` is ignored while a load is in progress.
- R9: `timeout` stays set until the next accepted `start`. That start clears it and also clears `addrOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (accepted only when idle) |
| ctrlStatus | input | 16 | Command register read value; bit 15 = busy |
| dataWord | input | 16 | Data register read value |
| cmdWr | output | 1 | Write strobe for the command register |
| cmdWord | output | 16 | Command value written |
| addrOut | output | 48 | Assembled station address |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Sticky: at least one word timed out |

## Verification
The hardest case to reach is the poll-limit boundary, where busy falls on exactly the last permitted check or one check too late. The bench's register stub holds busy for a programmable number of cycles after each command. The counts are chosen so that busy clears on check 1000 in one run and on check 1001 in another. While busy, the stub drives a marker value on the data register, so any capture taken during busy shows up in `addrOut`. Another scenario leaves busy stuck for only the middle word, to show that the load continues past a timed-out word.

// File: rtl/sta_loader_pkg.sv
package sta_loader_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_POLL  = 2'd2
  } loaderState_t;

  typedef struct packed {
    logic clearAll;     // new load: wipe address, flag, index
    logic clearPoll;    // restart the poll counter
    logic incPoll;      // one more busy check seen
    logic captureWord;  // store the data register into the current slot
    logic captureZero;  // store zero into the current slot and flag timeout
    logic incIdx;       // advance to the next word
  } loaderStrobes_t;

endpackage

// File: rtl/sta_loader_dp.sv
module sta_loader_dp
  import sta_loader_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 3,
  parameter int MAX_POLLS = 1000,
  localparam int ADDR_W   = WORD_W * NUM_WORDS,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int CNT_W    = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  loaderStrobes_t    strobes,
  input  logic              busy,
  input  logic [WORD_W-1:0] dataWord,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              pollLast,
  output logic              idxLast,
  output logic [ADDR_W-1:0] addrOut,
  output logic              timeoutFlag
);

  logic [CNT_W-1:0] pollCnt;

  assign pollLast = (pollCnt == CNT_W'(MAX_POLLS - 1));
  assign idxLast  = (wordIdx == IDX_W'(NUM_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pollCnt <= '0;
    end else if (strobes.clearPoll) begin
      pollCnt <= '0;
    end else if (strobes.incPoll) begin
      pollCnt <= pollCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.clearAll) begin
      wordIdx <= '0;
    end else if (strobes.incIdx) begin
      wordIdx <= wordIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.clearAll) begin
      addrOut <= '0;
    end else begin
      for (int k = 0; k < NUM_WORDS; k++) begin
        if (wordIdx == IDX_W'(k)) begin
          if (strobes.captureWord) addrOut[k*WORD_W +: WORD_W] <= dataWord;
          else if (strobes.captureZero) addrOut[k*WORD_W +: WORD_W] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.clearAll) begin
      timeoutFlag <= 1'b0;
    end else if (strobes.captureZero) begin
      timeoutFlag <= 1'b1;
    end
  end

  // R4: data is only stored while the controller reports ready
  p_capture_ready_r4: assert property (@(posedge clk) disable iff (rst)
    strobes.captureWord |-> !busy);

  // R6: the poll counter never runs past the limit
  p_poll_bound_r6: assert property (@(posedge clk) disable iff (rst)
    pollCnt < CNT_W'(MAX_POLLS));

  // R9: timeout is sticky until a new load clears it
  p_timeout_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (timeoutFlag && !strobes.clearAll) |=> timeoutFlag);

endmodule

// File: rtl/sta_loader_ctrl.sv
module sta_loader_ctrl
  import sta_loader_pkg::*;
#(
  parameter int          NUM_WORDS = 3,
  parameter logic [7:0]  BASE_ADDR = 8'h10,
  parameter logic [15:0] READ_OP   = 16'h0200,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             busy,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic             pollLast,
  input  logic             idxLast,
  output loaderStrobes_t   strobes,
  output logic             cmdWr,
  output logic [15:0]      cmdWord,
  output logic             done
);

  loaderState_t state, stateNext;
  logic         wordEnd;
  logic [7:0]   wordAddr;

  assign wordAddr = BASE_ADDR + 8'(wordIdx);
  assign cmdWr    = (state == ST_ISSUE);
  assign cmdWord  = READ_OP | {8'h00, wordAddr};
  assign wordEnd  = strobes.captureWord || strobes.captureZero;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.clearAll = 1'b1;
          stateNext        = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        strobes.clearPoll = 1'b1;
        stateNext         = ST_POLL;
      end
      ST_POLL: begin
        if (!busy) begin
          strobes.captureWord = 1'b1;
        end else if (pollLast) begin
          strobes.captureZero = 1'b1;
        end else begin
          strobes.incPoll = 1'b1;
        end
        if (!busy || pollLast) begin
          if (idxLast) begin
            stateNext = ST_IDLE;
          end else begin
            strobes.incIdx = 1'b1;
            stateNext      = ST_ISSUE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= wordEnd && idxLast;
    end
  end

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: one command strobe per word, never back to back
  p_single_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    cmdWr |=> !cmdWr);

  // R3: every command addresses a word inside the fetched run
  p_cmd_range_r3: assert property (@(posedge clk) disable iff (rst)
    cmdWr |-> (cmdWord[7:0] >= BASE_ADDR && cmdWord[7:0] < BASE_ADDR + 8'(NUM_WORDS)));

  // R8: a start while busy does not restart the sequence
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POLL && start && busy && !pollLast) |=> state == ST_POLL);

endmodule

// File: rtl/sta_addr_loader.sv
module sta_addr_loader
  import sta_loader_pkg::*;
#(
  parameter int          WORD_W    = 16,
  parameter int          NUM_WORDS = 3,
  parameter int          MAX_POLLS = 1000,
  parameter int          BUSY_BIT  = 15,
  parameter logic [7:0]  BASE_ADDR = 8'h10,
  parameter logic [15:0] READ_OP   = 16'h0200,
  localparam int ADDR_W = WORD_W * NUM_WORDS,
  localparam int IDX_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [15:0]       ctrlStatus,
  input  logic [WORD_W-1:0] dataWord,
  output logic              cmdWr,
  output logic [15:0]       cmdWord,
  output logic [ADDR_W-1:0] addrOut,
  output logic              done,
  output logic              timeout
);

  loaderStrobes_t   strobes;
  logic             busy;
  logic             pollLast;
  logic             idxLast;
  logic [IDX_W-1:0] wordIdx;
  logic             unusedStatus;

  assign busy         = ctrlStatus[BUSY_BIT];
  assign unusedStatus = ^ctrlStatus;

  sta_loader_ctrl #(
    .NUM_WORDS (NUM_WORDS),
    .BASE_ADDR (BASE_ADDR),
    .READ_OP   (READ_OP)
  ) ctrlInst (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .wordIdx  (wordIdx),
    .pollLast (pollLast),
    .idxLast  (idxLast),
    .strobes  (strobes),
    .cmdWr    (cmdWr),
    .cmdWord  (cmdWord),
    .done     (done)
  );

  sta_loader_dp #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .MAX_POLLS (MAX_POLLS)
  ) dpInst (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .busy        (busy),
    .dataWord    (dataWord),
    .wordIdx     (wordIdx),
    .pollLast    (pollLast),
    .idxLast     (idxLast),
    .addrOut     (addrOut),
    .timeoutFlag (timeout)
  );

  // R1: nothing is commanded right after reset without a start
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!cmdWr && !done && !timeout && addrOut == '0));

endmodule

// File: tb/sta_addr_loader_test.sv
module sta_addr_loader_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [15:0] ctrlStatus;
  logic [15:0] dataWord;
  logic        cmdWr;
  logic [15:0] cmdWord;
  logic [47:0] addrOut;
  logic        done;
  logic        timeout;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sta_addr_loader uut (
    .clk(clk), .rst(rst), .start(start), .ctrlStatus(ctrlStatus),
    .dataWord(dataWord), .cmdWr(cmdWr), .cmdWord(cmdWord),
    .addrOut(addrOut), .done(done), .timeout(timeout)
  );

  // register stub: busy for delayTab[word] cycles after each command
  localparam int STUCK = 32'h7fffffff;
  logic [15:0] memTab [3];
  int          delayTab [3];
  int          stubCnt;
  logic        stubBusy;
  logic [7:0]  stubAddr;
  logic [15:0] cmdLog [8];
  int          cmdCount;

  assign ctrlStatus = {stubBusy, 15'h0123};
  assign dataWord   = stubBusy ? 16'hBAD0 : memTab[stubAddr[1:0] % 3];

  always_ff @(posedge clk) begin
    if (rst) begin
      stubBusy <= 1'b0;
      stubCnt  <= 0;
      stubAddr <= 8'h10;
    end else if (cmdWr) begin
      stubBusy <= 1'b1;
      stubAddr <= cmdWord[7:0] - 8'h10;
      stubCnt  <= delayTab[(cmdWord[7:0] - 8'h10) % 3];
      if (cmdCount < 8) cmdLog[cmdCount] <= cmdWord;
      cmdCount <= cmdCount + 1;
    end else if (stubBusy && stubCnt != STUCK) begin
      if (stubCnt == 0) stubBusy <= 1'b0;
      else stubCnt <= stubCnt - 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                       input int d0, input int d1, input int d2);
    memTab[0] = w0; memTab[1] = w1; memTab[2] = w2;
    delayTab[0] = d0; delayTab[1] = d1; delayTab[2] = d2;
    @(negedge clk); cmdCount = 0;
  endtask

  task automatic testReset();
    rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(addrOut == 48'h0, "R1 addrOut", addrOut, 48'h0);
    check(!done && !timeout, "R1 flags", {done, timeout}, 0);
    check(!cmdWr, "R1 cmdWr", cmdWr, 0);
  endtask

  task automatic testNormal();
    bit seen;
    setup(16'h2211, 16'h4433, 16'h6655, 0, 3, 7);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(cmdWr && cmdWord == 16'h0210, "R2 first command", {cmdWr, cmdWord}, {1'b1, 16'h0210});
    waitDone(seen);
    check(seen, "R7 done seen", seen, 1);
    check(addrOut == 48'h665544332211, "R5 byte placement", addrOut, 48'h665544332211);
    check(addrOut[7:0] == 8'h11, "R5 first byte low", addrOut[7:0], 8'h11);
    check(addrOut != 48'hBAD0 && addrOut[31:16] != 16'hBAD0 && addrOut[47:32] != 16'hBAD0,
          "R4 no busy capture", addrOut, 48'h665544332211);
    check(!timeout, "R6 no timeout", timeout, 0);
    check(cmdCount == 3, "R3 command count", cmdCount, 3);
    check(cmdLog[0] == 16'h0210 && cmdLog[1] == 16'h0211 && cmdLog[2] == 16'h0212,
          "R3 command order", {cmdLog[0], cmdLog[1], cmdLog[2]}, 48'h021002110212);
    @(negedge clk);
    check(!done, "R7 done one cycle", done, 0);
  endtask

  task automatic testStartIgnored();
    bit seen;
    setup(16'hA1A0, 16'hB1B0, 16'hC1C0, 20, 20, 20);
    pulseStart();
    repeat (10) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (15) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    waitDone(seen);
    check(seen && cmdCount == 3, "R8 start ignored count", cmdCount, 3);
    check(addrOut == 48'hC1C0B1B0A1A0, "R8 result intact", addrOut, 48'hC1C0B1B0A1A0);
  endtask

  task automatic testBoundaryOk();
    bit seen;
    // busy clears on check 1000 for the first word
    setup(16'h1357, 16'h2468, 16'h9ABC, 998, 0, 0);
    pulseStart();
    waitDone(seen);
    check(seen && !timeout, "R6 clear on 1000th check", timeout, 0);
    check(addrOut == 48'h9ABC24681357, "R6 word captured at limit", addrOut, 48'h9ABC24681357);
  endtask

  task automatic testBoundaryLate();
    bit seen;
    // busy would clear on check 1001: one check too late
    setup(16'h1357, 16'h2468, 16'h9ABC, 999, 0, 0);
    pulseStart();
    waitDone(seen);
    check(seen && timeout, "R6 timeout at 1001", timeout, 1);
    check(addrOut == 48'h9ABC24680000, "R6 zero word", addrOut, 48'h9ABC24680000);
  endtask

  task automatic testStuckMiddle();
    bit seen;
    setup(16'hFEED, 16'hBEEF, 16'hCAFE, 2, STUCK, 1);
    pulseStart();
    waitDone(seen);
    check(seen && timeout, "R6 stuck middle timeout", timeout, 1);
    check(addrOut == 48'hCAFE0000FEED, "R6 load continues", addrOut, 48'hCAFE0000FEED);
    check(cmdCount == 3, "R3 count with timeout", cmdCount, 3);
    repeat (4) @(negedge clk);
    check(timeout, "R9 timeout sticky", timeout, 1);
  endtask

  task automatic testRestartClears();
    bit seen;
    setup(16'h0102, 16'h0304, 16'h0506, 30, 0, 0);
    pulseStart();
    check(!timeout && addrOut == 48'h0, "R9 cleared on start", {timeout, addrOut}, 0);
    waitDone(seen);
    check(seen && !timeout && addrOut == 48'h050603040102, "R9 clean reload", addrOut, 48'h050603040102);
  endtask

  bit finished = 1'b0;

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    memTab[0] = 0; memTab[1] = 0; memTab[2] = 0;
    delayTab[0] = 0; delayTab[1] = 0; delayTab[2] = 0;
    cmdCount = 0;
    testReset();
    testNormal();
    testStartIgnored();
    testBoundaryOk();
    testBoundaryLate();
    testStuckMiddle();
    testRestartClears();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule